// File: doc/BRIEF.md
# I2C Write-Only Target with Per-Byte Hold

This block is a 7-bit-address I2C target that accepts write transfers. The two bus wires are brought into the system clock domain through a synchronizer. Start and Stop conditions are recognised as SDA edges while SCL is high. Every byte is shifted in on rising SCL edges. A byte that the target accepts is placed in a single receive buffer, and a one-cycle event pulse marks each accepted byte. The target acknowledges by pulling SDA low. It can hold SCL low (clock stretching) until the local host lets it go. The open-drain pins appear as two drive-low enables.

A local host sees sticky status: start seen, stop seen, direction, buffer full, overflow, interrupt flag and an ACK-phase marker. It acts through single-cycle strobes: read buffer, clear interrupt, clear overflow and release clock. Two hold modes, one for address bytes and one for data bytes, stop the bus after the 8th falling SCL edge. In a hold, the host reads the byte and then picks ACK or NACK through the `ack_nack_i` level before it releases the clock.

Top module: `i2c_hold_rx`

## Requirements
- R1: After reset, every status output is 0, `clk_rel_o` is 1 and neither bus wire is driven low.
- R2: A Start (SDA falling while SCL is high) sets `start_seen_o` and clears `stop_seen_o`. It sets `irq_o` only when `start_irq_en_i` is 1.
- R3: An address byte is 7 address bits, MSB first, followed by a direction bit (0 = write). When its upper 7 bits equal `own_addr_i` and the direction bit is 0, the whole 8-bit byte is loaded into `rx_data_o`, `buf_full_o` is set, `rw_o` is 0 and SDA is pulled low during the 9th clock. Any other address is neither acknowledged nor loaded, and the rest of that transfer is ignored.
- R4: Each data byte after an accepted address is loaded MSB first into `rx_data_o` and acknowledged. Each accepted byte gives exactly one single-cycle `byte_evt_o` pulse.
- R5: If `buf_full_o` or `ovf_o` is 1 when the 8th falling edge of a byte arrives, the byte is NACKed and `rx_data_o` keeps its old value. If `buf_full_o` was 1, `ovf_o` is set. The rest of the transfer is then ignored.
- R6: `rd_buf_i` clears `buf_full_o` and leaves `ovf_o` unchanged. Only `clr_ovf_i` clears `ovf_o`.
- R7: `irq_o` is set at the 9th falling SCL edge of every acknowledged byte, but not of a NACKed byte. Only `clr_irq_i` clears it.
- R8: With `stretch_en_i` at 1, SCL is held low (`scl_drive_low_o` = 1, `clk_rel_o` = 0) from the 9th falling edge of each acknowledged byte until `release_i` is pulsed.
- R9: With `addr_hold_i` (address byte) or `data_hold_i` (data byte) at 1, the 8th falling edge clears `clk_rel_o`, holds SCL low and sets `irq_o`. The bit sent in the 9th clock is then ACK when `ack_nack_i` = 0 and NACK when `ack_nack_i` = 1.
- R10: `ack_tim_o` is 1 from the 8th falling SCL edge of an accepted byte until its 9th falling edge, and 0 otherwise. SDA is driven low only while it is 1.
- R11: A Stop (SDA rising while SCL is high) sets `stop_seen_o`, clears `start_seen_o` and returns the target to idle. It sets `irq_o` only when `stop_irq_en_i` is 1.
- R12: An address whose upper 7 bits match and whose direction bit is 1 sets `rw_o` to 1. It is NACKed and not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | Pull SCL low (stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low (ACK) |
| own_addr_i | input | ADDR_W | Target address |
| stretch_en_i | input | 1 | Stretch after each acknowledged byte |
| addr_hold_i | input | 1 | Hold after the 8th edge of the address byte |
| data_hold_i | input | 1 | Hold after the 8th edge of data bytes |
| start_irq_en_i | input | 1 | Start raises the interrupt |
| stop_irq_en_i | input | 1 | Stop raises the interrupt |
| ack_nack_i | input | 1 | Host ACK choice in hold, 1 = NACK |
| release_i | input | 1 | Strobe: release SCL |
| rd_buf_i | input | 1 | Strobe: buffer read, clears full |
| clr_irq_i | input | 1 | Strobe: clear interrupt flag |
| clr_ovf_i | input | 1 | Strobe: clear overflow |
| rx_data_o | output | ADDR_W+1 | Receive buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | Byte arrived while buffer full |
| irq_o | output | 1 | Sticky interrupt flag |
| start_seen_o | output | 1 | Start detected |
| stop_seen_o | output | 1 | Stop detected |
| rw_o | output | 1 | Direction bit of last matching address |
| ack_tim_o | output | 1 | In the ACK phase of a byte |
| clk_rel_o | output | 1 | Clock released (0 = holding SCL) |
| byte_evt_o | output | 1 | One-cycle pulse per accepted byte |

## Verification
The assertions assume a well-behaved controller. It moves SDA only while SCL is low, except for Start and Stop, and every SCL phase lasts longer than the synchronizer delay. They also assume the host never pulses `release_i` in the same cycle that the target begins a stretch. The bench's bus model wire-ANDs its own drive with the target's pull-downs. It changes SDA only in the low half of SCL, keeps every quarter bit at eight clocks, and waits for the SCL line to read high before it counts a clock, so it honours every stretch. Host strobes are issued only while SCL is held or between transfers.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,  // no transfer
    PH_BITS,  // shifting 8 bits
    PH_ACK,   // between 8th and 9th falling SCL edge
    PH_SKIP   // not addressed or NACKed, wait for Start/Stop
  } phase_e;
endpackage

// File: rtl/i2c_hold_sync.sv
module i2c_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;  // idle bus is high
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_hold_cond.sv
module i2c_hold_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign scl_rise_o = ~scl_q & scl_s_i;
  assign scl_fall_o = scl_q & ~scl_s_i;
endmodule

// File: rtl/i2c_hold_rx.sv
module i2c_hold_rx
  import i2c_hold_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low_o,
  output logic              sda_drive_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              stretch_en_i,
  input  logic              addr_hold_i,
  input  logic              data_hold_i,
  input  logic              start_irq_en_i,
  input  logic              stop_irq_en_i,
  input  logic              ack_nack_i,
  input  logic              release_i,
  input  logic              rd_buf_i,
  input  logic              clr_irq_i,
  input  logic              clr_ovf_i,
  output logic [ADDR_W:0]   rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              start_seen_o,
  output logic              stop_seen_o,
  output logic              rw_o,
  output logic              ack_tim_o,
  output logic              clk_rel_o,
  output logic              byte_evt_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;

  i2c_hold_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_hold_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_hold_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

  phase_e            phase_q;
  logic              is_addr_q, hold_q, nack_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, rx_q;
  logic full_q, ovf_q, irq_q, start_q, stop_q, rw_q, rel_q, evt_q;

  logic addr_hit, accept, hold_now, ack_low;

  assign addr_hit = (shift_q[BYTE_W-1:1] == own_addr_i);
  assign accept   = is_addr_q ? (addr_hit && !shift_q[0]) : 1'b1;
  assign hold_now = is_addr_q ? addr_hold_i : data_hold_i;
  // ACK needs room in the buffer and, in a hold, the host's consent
  assign ack_low  = (phase_q == PH_ACK) && !nack_q && !(hold_q && ack_nack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      is_addr_q <= 1'b0;
      hold_q    <= 1'b0;
      nack_q    <= 1'b0;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      rx_q      <= '0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      irq_q     <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      rw_q      <= 1'b0;
      rel_q     <= 1'b1;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      // host strobes first so that hardware sets in the same cycle win
      if (release_i) rel_q  <= 1'b1;
      if (rd_buf_i)  full_q <= 1'b0;
      if (clr_irq_i) irq_q  <= 1'b0;
      if (clr_ovf_i) ovf_q  <= 1'b0;

      if (start_det) begin
        start_q   <= 1'b1;
        stop_q    <= 1'b0;
        phase_q   <= PH_BITS;
        is_addr_q <= 1'b1;
        bit_cnt_q <= '0;
        if (start_irq_en_i) irq_q <= 1'b1;
      end else if (stop_det) begin
        stop_q  <= 1'b1;
        start_q <= 1'b0;
        phase_q <= PH_IDLE;
        if (stop_irq_en_i) irq_q <= 1'b1;
      end else begin
        unique case (phase_q)
          PH_BITS: begin
            if (scl_rise && bit_cnt_q < LAST_BIT) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (is_addr_q && addr_hit) rw_q <= shift_q[0];
              if (!accept) begin
                phase_q <= PH_SKIP;
              end else begin
                phase_q <= PH_ACK;
                evt_q   <= 1'b1;
                nack_q  <= full_q | ovf_q;
                hold_q  <= hold_now;
                if (full_q) ovf_q <= 1'b1;
                else if (!ovf_q) begin
                  rx_q   <= shift_q;
                  full_q <= 1'b1;
                end
                if (hold_now) begin
                  rel_q <= 1'b0;
                  irq_q <= 1'b1;
                end
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              is_addr_q <= 1'b0;
              if (ack_low) begin
                irq_q   <= 1'b1;
                phase_q <= PH_BITS;
                if (stretch_en_i) rel_q <= 1'b0;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_drive_low_o = ~rel_q;
  assign sda_drive_low_o = ack_low;
  assign rx_data_o       = rx_q;
  assign buf_full_o      = full_q;
  assign ovf_o           = ovf_q;
  assign irq_o           = irq_q;
  assign start_seen_o    = start_q;
  assign stop_seen_o     = stop_q;
  assign rw_o            = rw_q;
  assign ack_tim_o       = (phase_q == PH_ACK);
  assign clk_rel_o       = rel_q;
  assign byte_evt_o      = evt_q;
endmodule

module i2c_hold_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_drive_low_o,
  input logic sda_drive_low_o,
  input logic release_i,
  input logic clr_irq_i,
  input logic clr_ovf_i,
  input logic buf_full_o,
  input logic ovf_o,
  input logic irq_o,
  input logic start_seen_o,
  input logic stop_seen_o,
  input logic ack_tim_o,
  input logic byte_evt_o
);
  // R10
  sda_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_drive_low_o |-> ack_tim_o);
  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_irq_i |=> irq_o);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_ovf_i |=> ovf_o);
  // R4
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt_o |=> !byte_evt_o);
  // R4
  full_with_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_full_o) |-> byte_evt_o);
  // R8
  stretch_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_low_o) |-> irq_o);
  // R8
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drive_low_o && !release_i |=> scl_drive_low_o);
  // R11
  stop_clears_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_seen_o) |-> !start_seen_o);
endmodule

bind i2c_hold_rx i2c_hold_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
  .release_i(release_i), .clr_irq_i(clr_irq_i), .clr_ovf_i(clr_ovf_i),
  .buf_full_o(buf_full_o), .ovf_o(ovf_o), .irq_o(irq_o),
  .start_seen_o(start_seen_o), .stop_seen_o(stop_seen_o),
  .ack_tim_o(ack_tim_o), .byte_evt_o(byte_evt_o));

// File: tb/i2c_hold_rx_test.sv
module i2c_hold_rx_test;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h42;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_drive_low_o, sda_drive_low_o;
  logic stretch_en = 0, addr_hold = 0, data_hold = 0;
  logic start_irq_en = 0, stop_irq_en = 0, ack_nack = 0;
  logic release_s = 0, rd_buf = 0, clr_irq = 0, clr_ovf = 0;
  logic [7:0] rx_data;
  logic buf_full, ovf, irq, start_seen, stop_seen, rw, ack_tim, clk_rel, byte_evt;

  wire scl_line = scl_m & ~scl_drive_low_o;
  wire sda_line = sda_m & ~sda_drive_low_o;

  i2c_hold_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
    .own_addr_i(OWN), .stretch_en_i(stretch_en), .addr_hold_i(addr_hold),
    .data_hold_i(data_hold), .start_irq_en_i(start_irq_en),
    .stop_irq_en_i(stop_irq_en), .ack_nack_i(ack_nack), .release_i(release_s),
    .rd_buf_i(rd_buf), .clr_irq_i(clr_irq), .clr_ovf_i(clr_ovf),
    .rx_data_o(rx_data), .buf_full_o(buf_full), .ovf_o(ovf), .irq_o(irq),
    .start_seen_o(start_seen), .stop_seen_o(stop_seen), .rw_o(rw),
    .ack_tim_o(ack_tim), .clk_rel_o(clk_rel), .byte_evt_o(byte_evt));

  int checks = 0, errors = 0, evt_cnt = 0;

  always @(negedge clk) if (rst_ni && byte_evt) evt_cnt <= evt_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_high(); wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_high(); wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send8(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; wq();
      scl_high(); wq();
      scl_m = 1'b0; wq();
    end
  endtask

  task automatic ack_clk(output logic a);
    sda_m = 1'b1; wq();
    scl_high(); repeat (Q/2) @(negedge clk);
    a = ~sda_line;
    repeat (Q/2) @(negedge clk);
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic a);
    send8(d);
    ack_clk(a);
  endtask

  task automatic do_rd();      rd_buf = 1;    @(negedge clk); rd_buf = 0;    @(negedge clk); endtask
  task automatic do_clr_irq(); clr_irq = 1;   @(negedge clk); clr_irq = 0;   @(negedge clk); endtask
  task automatic do_clr_ovf(); clr_ovf = 1;   @(negedge clk); clr_ovf = 0;   @(negedge clk); endtask
  task automatic do_release(); release_s = 1; @(negedge clk); release_s = 0; @(negedge clk); endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 full", buf_full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 start/stop", {start_seen, stop_seen}, 0);
    chk("R1 clk_rel", clk_rel, 1);
    chk("R1 drives", {scl_drive_low_o, sda_drive_low_o}, 0);
  endtask

  task automatic t_start_stop();
    start_irq_en = 1; stop_irq_en = 0;
    bus_start();
    chk("R2 start_seen", start_seen, 1);
    chk("R2 irq with enable", irq, 1);
    do_clr_irq();
    bus_stop();
    chk("R11 stop_seen", stop_seen, 1);
    chk("R11 start cleared", start_seen, 0);
    chk("R11 no irq when disabled", irq, 0);
    start_irq_en = 0;
    bus_start();
    chk("R2 no irq when disabled", irq, 0);
    chk("R2 stop cleared", stop_seen, 0);
    bus_stop();
  endtask

  task automatic t_write();
    logic a;
    int e0;
    e0 = evt_cnt;
    stop_irq_en = 1;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R3 addr ack", a, 1);
    chk("R3 addr loaded", rx_data, {OWN, 1'b0});
    chk("R3 full", buf_full, 1);
    chk("R3 rw", rw, 0);
    chk("R7 irq after ack", irq, 1);
    chk("R10 ack_tim low after 9th", ack_tim, 0);
    do_rd(); do_clr_irq();
    chk("R6 rd clears full", buf_full, 0);
    send_byte(8'h5A, a);
    chk("R4 data ack", a, 1);
    chk("R4 data value", rx_data, 8'h5A);
    do_rd(); do_clr_irq();
    send_byte(8'hC3, a);
    chk("R4 data value 2", rx_data, 8'hC3);
    chk("R4 evt count", evt_cnt - e0, 3);
    do_rd(); do_clr_irq();
    bus_stop();
    chk("R11 irq with enable", irq, 1);
    do_clr_irq();
    stop_irq_en = 0;
  endtask

  task automatic t_nomatch();
    logic a;
    bus_start();
    send_byte(8'h40, a);
    chk("R3 no ack other addr", a, 0);
    chk("R3 not loaded", buf_full, 0);
    send_byte(8'hFF, a);
    chk("R3 rest ignored", {a, buf_full, irq}, 0);
    bus_stop();
  endtask

  task automatic t_read_addr();
    logic a;
    bus_start();
    send_byte({OWN, 1'b1}, a);
    chk("R12 read nacked", a, 0);
    chk("R12 rw set", rw, 1);
    chk("R12 not loaded", buf_full, 0);
    bus_stop();
  endtask

  task automatic t_overflow();
    logic a;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    do_clr_irq();
    send_byte(8'h11, a);
    chk("R5 nack on full", a, 0);
    chk("R5 ovf set", ovf, 1);
    chk("R5 buffer kept", rx_data, {OWN, 1'b0});
    chk("R7 no irq on nack", irq, 0);
    send_byte(8'h22, a);
    chk("R5 ignored after nack", {a, rx_data}, {1'b0, OWN, 1'b0});
    do_rd();
    chk("R6 full cleared, ovf kept", {buf_full, ovf}, 2'b01);
    do_clr_ovf();
    chk("R6 ovf cleared", ovf, 0);
    bus_stop();
  endtask

  task automatic t_stretch();
    logic a;
    stretch_en = 1;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R8 scl held", {scl_drive_low_o, clk_rel}, 2'b10);
    repeat (20) @(negedge clk);
    chk("R8 still held", scl_drive_low_o, 1);
    do_rd(); do_clr_irq(); do_release();
    chk("R8 released", {scl_drive_low_o, clk_rel}, 2'b01);
    send_byte(8'hA5, a);
    chk("R8 data ack", a, 1);
    chk("R8 held after data", scl_drive_low_o, 1);
    do_rd(); do_clr_irq(); do_release();
    stretch_en = 0;
    bus_stop();
  endtask

  task automatic t_hold();
    logic a;
    addr_hold = 1; data_hold = 1;
    bus_start();
    send8({OWN, 1'b0});
    chk("R9 addr hold scl", {scl_drive_low_o, clk_rel}, 2'b10);
    chk("R9 addr hold irq", irq, 1);
    chk("R10 ack_tim in hold", ack_tim, 1);
    chk("R9 addr in buffer", rx_data, {OWN, 1'b0});
    do_clr_irq();
    ack_nack = 0;
    do_release();
    ack_clk(a);
    chk("R9 host ack", a, 1);
    chk("R10 ack_tim after 9th", ack_tim, 0);
    chk("R7 irq after ack in hold", irq, 1);
    do_rd(); do_clr_irq();
    send8(8'h33);
    chk("R9 data hold", {scl_drive_low_o, irq, ack_tim}, 3'b111);
    do_clr_irq();
    ack_nack = 1;
    do_release();
    ack_clk(a);
    chk("R9 host nack", a, 0);
    chk("R7 no irq after nack", irq, 0);
    chk("R9 data loaded", rx_data, 8'h33);
    do_rd();
    ack_nack = 0; addr_hold = 0; data_hold = 0;
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_stop();
    t_write();
    t_nomatch();
    t_read_addr();
    t_overflow();
    t_stretch();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule